// File: doc/BRIEF.md
# Fractional Clock Divider with Alternating Divide Ratios

This block derives a slow clock, for example a precise 32.768 kHz tick, from a faster reference. A single integer ratio often cannot reach such a frequency exactly. The block therefore alternates between two integer ratios. It runs the first ratio for a programmed number of output periods, then runs the second ratio for its own programmed number of periods, and then starts over. The long-run output frequency is f_ref × (M1 + M2) / (N1·M1 + N2·M2). In single mode only the first ratio is used, and the output frequency is f_ref / N1.

The four configuration fields are each FIELD_W bits wide. Each field stores its real value minus one. The configuration and the mode bit are captured in shadow registers and are copied into the working set only on a sequence boundary. As a result, a software update never produces a shortened or distorted period. The output is a registered, glitch-free clock-enable. A one-cycle strobe marks each switch between the two ratios.

Top module: `frac_clk_div`

## Requirements
- R1: In single mode (`mode_dual_i` = 0), rising edges of `div_clk_o` are exactly N1 reference cycles apart, where N1 = `div_a_i` + 1.
- R2: Within each output period of ratio N, `div_clk_o` is high for floor(N/2) cycles and low for the remaining cycles. When N = 1, `div_clk_o` stays high continuously while enabled.
- R3: In dual mode (`mode_dual_i` = 1), the block produces M1 periods of N1 cycles, then M2 periods of N2 cycles, where N2 = `div_b_i` + 1, M1 = `rep_a_i` + 1 and M2 = `rep_b_i` + 1. This order repeats indefinitely.
- R4: One full dual sequence spans exactly N1·M1 + N2·M2 reference cycles and contains M1 + M2 rising edges.
- R5: A field value of 0 means a ratio or repeat count of 1.
- R6: While enabled, a change to the fields or to the mode bit takes effect only after the current sequence completes. In dual mode a sequence is the full M1+M2 run; in single mode it is one period.
- R7: One cycle after `en` is sampled low, `div_clk_o` and `phase_stb_o` are both low. When `en` is raised again, the block restarts with a full N1 period.
- R8: `phase_stb_o` pulses high for one cycle immediately before the first rising edge of every period that begins a new phase (switches between ratio 1 and ratio 2 in both directions). It never pulses in single mode, and it does not pulse on the first period after enable.
- R9: During reset, and afterwards until `en` is raised, `div_clk_o` and `phase_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle and cleared |
| mode_dual_i | input | 1 | 0 = single ratio, 1 = alternating ratios |
| div_a_i | input | FIELD_W | First divide ratio minus one |
| rep_a_i | input | FIELD_W | Period count for the first ratio minus one |
| div_b_i | input | FIELD_W | Second divide ratio minus one |
| rep_b_i | input | FIELD_W | Period count for the second ratio minus one |
| div_clk_o | output | 1 | Registered divided clock / clock-enable |
| phase_stb_o | output | 1 | One-cycle pulse at each switch between ratios |

## Verification
A corrupted divide counter shows up within one output period: the next interval between rising edges, or the high time, no longer matches the ratio. A repeat counter or phase register that has drifted shows up within one sequence in two ways: the period where the length changes is in the wrong place, and a strobe is missing or misplaced. A configuration that is applied too early or too late appears as a wrong period length in the sequence that straddles the update. The bench therefore compares every period and every strobe position against a precomputed expected stream.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;

   // Which of the two divide ratios is currently driving the output.
   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } fcd_phase_e;

   localparam int FCD_MIN_FIELD_W = 2;
   localparam int FCD_MAX_FIELD_W = 16;

endpackage

// File: rtl/fcd_cfg_hold.sv
module fcd_cfg_hold #(
   parameter int FW       = 12,
   parameter bit SYNC_CFG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          seq_end,
   input  logic          dual_i,
   input  logic [FW-1:0] n1_i,
   input  logic [FW-1:0] m1_i,
   input  logic [FW-1:0] n2_i,
   input  logic [FW-1:0] m2_i,
   output logic          dual_q,
   output logic [FW-1:0] n1_q,
   output logic [FW-1:0] m1_q,
   output logic [FW-1:0] n2_q,
   output logic [FW-1:0] m2_q
);

   localparam int CW = 1 + 4 * FW;

   logic [CW-1:0] in_vec;
   logic [CW-1:0] src_vec;
   logic [CW-1:0] act_vec;
   logic          load;

   assign in_vec = {dual_i, n1_i, m1_i, n2_i, m2_i};

   generate
      if (SYNC_CFG) begin : g_shadow
         // Inputs are captured every cycle; the working set copies from here.
         logic [CW-1:0] shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shadow_q <= '0;
            else        shadow_q <= in_vec;
         end
         assign src_vec = shadow_q;
      end else begin : g_direct
         assign src_vec = in_vec;
      end
   endgenerate

   // The working set only moves while idle or on a sequence boundary.
   assign load = !en || seq_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_vec <= '0;
      else if (load) act_vec <= src_vec;
   end

   assign {dual_q, n1_q, m1_q, n2_q, m2_q} = act_vec;

endmodule

// File: rtl/fcd_period_cnt.sv
module fcd_period_cnt #(
   parameter int FW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [FW-1:0] div_nm1,
   output logic [FW-1:0] cnt_q,
   output logic          period_end,
   output logic          high_now
);

   localparam int NW = FW + 1;

   logic [NW-1:0] half;

   // floor(N/2) with N = div_nm1 + 1, computed one bit wider than the field.
   assign half       = ({1'b0, div_nm1} + NW'(1)) >> 1;
   assign high_now   = ({1'b0, cnt_q} < half) || (div_nm1 == '0);
   assign period_end = run && (cnt_q == div_nm1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (period_end) cnt_q <= '0;
      else                 cnt_q <= cnt_q + FW'(1);
   end

endmodule

// File: rtl/fcd_phase_seq.sv
module fcd_phase_seq
   import frac_clk_div_pkg::*;
#(
   parameter int FW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          period_end,
   input  logic          dual,
   input  logic [FW-1:0] m1,
   input  logic [FW-1:0] m2,
   output fcd_phase_e    phase_q,
   output logic [FW-1:0] rep_q,
   output logic [FW-1:0] rep_lim,
   output logic          seq_end,
   output logic          switch_now
);

   logic last_rep;

   assign rep_lim    = (phase_q == PH_B) ? m2 : m1;
   assign last_rep   = (rep_q == rep_lim);
   assign seq_end    = period_end && (!dual || (phase_q == PH_B && last_rep));
   assign switch_now = period_end && dual && last_rep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_A;
         rep_q   <= '0;
      end else if (!run) begin
         phase_q <= PH_A;
         rep_q   <= '0;
      end else if (period_end) begin
         if (seq_end) begin
            phase_q <= PH_A;
            rep_q   <= '0;
         end else if (switch_now) begin
            phase_q <= PH_B;
            rep_q   <= '0;
         end else begin
            rep_q   <= rep_q + FW'(1);
         end
      end
   end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import frac_clk_div_pkg::*;
#(
   parameter int FIELD_W  = 12,
   parameter bit SYNC_CFG = 1'b1
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic               en,
   input  logic               mode_dual_i,
   input  logic [FIELD_W-1:0] div_a_i,
   input  logic [FIELD_W-1:0] rep_a_i,
   input  logic [FIELD_W-1:0] div_b_i,
   input  logic [FIELD_W-1:0] rep_b_i,
   output logic               div_clk_o,
   output logic               phase_stb_o
);

   generate
      if (FIELD_W < FCD_MIN_FIELD_W || FIELD_W > FCD_MAX_FIELD_W) begin : g_bad_width
         $error("frac_clk_div: FIELD_W out of supported range");
      end
   endgenerate

   logic               act_dual;
   logic [FIELD_W-1:0] act_n1;
   logic [FIELD_W-1:0] act_m1;
   logic [FIELD_W-1:0] act_n2;
   logic [FIELD_W-1:0] act_m2;
   logic [FIELD_W-1:0] cnt_q;
   logic [FIELD_W-1:0] cur_div;
   logic [FIELD_W-1:0] rep_q;
   logic [FIELD_W-1:0] rep_lim;
   logic               period_end;
   logic               high_now;
   logic               seq_end;
   logic               switch_now;
   fcd_phase_e         phase_q;

   fcd_cfg_hold #(
      .FW       (FIELD_W),
      .SYNC_CFG (SYNC_CFG)
   ) u_cfg (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .en      (en),
      .seq_end (seq_end),
      .dual_i  (mode_dual_i),
      .n1_i    (div_a_i),
      .m1_i    (rep_a_i),
      .n2_i    (div_b_i),
      .m2_i    (rep_b_i),
      .dual_q  (act_dual),
      .n1_q    (act_n1),
      .m1_q    (act_m1),
      .n2_q    (act_n2),
      .m2_q    (act_m2)
   );

   assign cur_div = (phase_q == PH_B) ? act_n2 : act_n1;

   fcd_period_cnt #(
      .FW (FIELD_W)
   ) u_cnt (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .run        (en),
      .div_nm1    (cur_div),
      .cnt_q      (cnt_q),
      .period_end (period_end),
      .high_now   (high_now)
   );

   fcd_phase_seq #(
      .FW (FIELD_W)
   ) u_seq (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .run        (en),
      .period_end (period_end),
      .dual       (act_dual),
      .m1         (act_m1),
      .m2         (act_m2),
      .phase_q    (phase_q),
      .rep_q      (rep_q),
      .rep_lim    (rep_lim),
      .seq_end    (seq_end),
      .switch_now (switch_now)
   );

   // Both outputs come straight from flops.
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         div_clk_o   <= 1'b0;
         phase_stb_o <= 1'b0;
      end else begin
         div_clk_o   <= en && high_now;
         phase_stb_o <= switch_now;
      end
   end

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
   parameter int FW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          div_clk_o,
   input logic          phase_stb_o,
   input logic          act_dual,
   input logic          seq_end,
   input logic [FW-1:0] cnt,
   input logic [FW-1:0] cur_div,
   input logic [FW-1:0] rep,
   input logic [FW-1:0] rep_lim,
   input logic [4*FW:0] act_cfg
);

   // R7: a low enable silences both outputs on the following cycle.
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!div_clk_o && !phase_stb_o));

   // R1: the divide counter never passes the ratio selected by the sequencer.
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cur_div);

   // R3: the repeat counter never passes the count of the current phase.
   p_rep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rep <= rep_lim);

   // R8: a strobe only follows a cycle in which dual mode was active.
   p_stb_dual_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      phase_stb_o |-> $past(act_dual));

   // R6: the working configuration holds steady inside a running sequence.
   p_cfg_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !seq_end) |=> $stable(act_cfg));

endmodule

bind frac_clk_div frac_clk_div_chk #(.FW(FIELD_W)) u_chk (
   .clk         (clk_ref),
   .rst_n       (rst_n),
   .en          (en),
   .div_clk_o   (div_clk_o),
   .phase_stb_o (phase_stb_o),
   .act_dual    (act_dual),
   .seq_end     (seq_end),
   .cnt         (cnt_q),
   .cur_div     (cur_div),
   .rep         (rep_q),
   .rep_lim     (rep_lim),
   .act_cfg     ({act_dual, act_n1, act_m1, act_n2, act_m2})
);

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;

   localparam int FW         = 12;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          en    = 1'b0;
   logic          dual  = 1'b0;
   logic [FW-1:0] n1    = '0;
   logic [FW-1:0] m1    = '0;
   logic [FW-1:0] n2    = '0;
   logic [FW-1:0] m2    = '0;
   logic          div_clk;
   logic          stb;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_clk_div #(.FIELD_W(FW)) u0 (
      .clk_ref     (clk),
      .rst_n       (rst_n),
      .en          (en),
      .mode_dual_i (dual),
      .div_a_i     (n1),
      .rep_a_i     (m1),
      .div_b_i     (n2),
      .rep_b_i     (m2),
      .div_clk_o   (div_clk),
      .phase_stb_o (stb)
   );

   typedef struct {
      int len;
      int high;
      bit stb;
   } exp_t;

   exp_t exp_q[$];
   int   stamps[$];
   int   checks = 0;
   int   fails  = 0;
   int   rises  = 0;
   int   cyc    = 0;
   bit   last_seq_dual = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int hi_len(input int n);
      return (n == 1) ? 1 : n / 2;
   endfunction

   // Driver side: expected periods of one sequence (real values, not minus one).
   task automatic push_seq(input bit d, input int a, input int ma, input int b, input int mb);
      if (!d) begin
         exp_q.push_back('{a, hi_len(a), last_seq_dual});
      end else begin
         for (int i = 0; i < ma; i++)
            exp_q.push_back('{a, hi_len(a), (i == 0) ? last_seq_dual : 1'b0});
         for (int i = 0; i < mb; i++)
            exp_q.push_back('{b, hi_len(b), (i == 0)});
      end
      last_seq_dual = d;
   endtask

   task automatic set_cfg(input bit d, input int a, input int ma, input int b, input int mb);
      dual = d;
      n1   = FW'(a - 1);
      m1   = FW'(ma - 1);
      n2   = FW'(b - 1);
      m2   = FW'(mb - 1);
   endtask

   task automatic start();
      repeat (3) @(negedge clk);
      en = 1'b1;
   endtask

   task automatic wait_rises(input int k);
      while (rises < k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic stop();
      en = 1'b0;
      @(negedge clk);
      check(div_clk == 1'b0, "R7", "clock after enable drop", int'(div_clk), 0);
      check(stb == 1'b0, "R7", "strobe after enable drop", int'(stb), 0);
      repeat (2) @(negedge clk);
      exp_q.delete();
      stamps.delete();
      rises = 0;
      last_seq_dual = 1'b0;
   endtask

   // Monitor: samples a quarter period after each rising edge.
   bit   mon_first = 1'b1;
   bit   mon_prev  = 1'b0;
   bit   mon_pstb  = 1'b0;
   int   mon_last  = 0;
   int   mon_hacc  = 0;
   exp_t mon_item;

   always begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      cyc++;
      if (!rst_n || !en) begin
         mon_first = 1'b1;
         mon_prev  = 1'b0;
         mon_hacc  = 0;
      end else if (div_clk && !mon_prev) begin
         rises++;
         stamps.push_back(cyc);
         if (!mon_first && exp_q.size() > 0) begin
            mon_item = exp_q.pop_front();
            check(cyc - mon_last == mon_item.len, "R1,R3", "period length",
                  cyc - mon_last, mon_item.len);
            check(mon_hacc == mon_item.high, "R2", "high time", mon_hacc, mon_item.high);
         end
         if (exp_q.size() > 0)
            check(mon_pstb == exp_q[0].stb, "R8", "strobe before period start",
                  int'(mon_pstb), int'(exp_q[0].stb));
         mon_first = 1'b0;
         mon_last  = cyc;
         mon_hacc  = 1;
         mon_prev  = 1'b1;
      end else begin
         if (div_clk) mon_hacc++;
         mon_prev = div_clk;
      end
      mon_pstb = stb;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   int highs;

   initial begin
      repeat (4) @(negedge clk);
      check(div_clk == 1'b0, "R9", "clock in reset", int'(div_clk), 0);
      check(stb == 1'b0, "R9", "strobe in reset", int'(stb), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(div_clk == 1'b0, "R9", "clock before enable", int'(div_clk), 0);

      // R1, R2: single mode, N=5
      set_cfg(1'b0, 5, 1, 1, 1);
      for (int i = 0; i < 8; i++) push_seq(1'b0, 5, 1, 1, 1);
      start();
      wait_rises(7);
      stop();

      // R2: single mode, N=2
      set_cfg(1'b0, 2, 1, 1, 1);
      for (int i = 0; i < 8; i++) push_seq(1'b0, 2, 1, 1, 1);
      start();
      wait_rises(7);
      stop();

      // R3, R4, R8: dual 3x2 then 4x3
      set_cfg(1'b1, 3, 2, 4, 3);
      for (int i = 0; i < 4; i++) push_seq(1'b1, 3, 2, 4, 3);
      start();
      wait_rises(16);
      check(stamps[5] - stamps[0] == 18, "R4", "cycles in sequence 0", stamps[5] - stamps[0], 18);
      check(stamps[10] - stamps[5] == 18, "R4", "cycles in sequence 1", stamps[10] - stamps[5], 18);
      check(stamps.size() >= 11, "R4", "rising edges seen", stamps.size(), 11);
      stop();

      // R5: zero fields for repeat counts, alternating 2 and 7
      set_cfg(1'b1, 2, 1, 7, 1);
      check(m1 == '0 && m2 == '0, "R5", "zero repeat fields", int'(m1) + int'(m2), 0);
      for (int i = 0; i < 6; i++) push_seq(1'b1, 2, 1, 7, 1);
      start();
      wait_rises(10);
      stop();

      // R6: update mid-sequence, dual to dual
      set_cfg(1'b1, 3, 2, 4, 3);
      for (int i = 0; i < 3; i++) push_seq(1'b1, 3, 2, 4, 3);
      start();
      wait_rises(12);
      set_cfg(1'b1, 5, 1, 2, 2);
      for (int i = 0; i < 3; i++) push_seq(1'b1, 5, 1, 2, 2);
      wait_rises(22);
      stop();

      // R6: update mid-sequence, dual to single
      set_cfg(1'b1, 3, 2, 4, 3);
      for (int i = 0; i < 2; i++) push_seq(1'b1, 3, 2, 4, 3);
      start();
      wait_rises(7);
      set_cfg(1'b0, 6, 1, 1, 1);
      for (int i = 0; i < 6; i++) push_seq(1'b0, 6, 1, 1, 1);
      wait_rises(14);
      stop();

      // R7: enable dropped mid-sequence, then restart from ratio 1
      set_cfg(1'b1, 3, 2, 4, 3);
      for (int i = 0; i < 3; i++) push_seq(1'b1, 3, 2, 4, 3);
      start();
      wait_rises(3);
      stop();
      for (int i = 0; i < 3; i++) push_seq(1'b1, 3, 2, 4, 3);
      start();
      wait_rises(12);
      check(stamps[1] - stamps[0] == 3, "R7", "first period after restart",
            stamps[1] - stamps[0], 3);
      stop();

      // R2, R5: all fields zero gives N=1, output held high
      set_cfg(1'b0, 1, 1, 1, 1);
      start();
      repeat (2) @(negedge clk);
      highs = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (div_clk && !stb) highs++;
      end
      check(highs == 16, "R2", "cycles high with N=1", highs, 16);
      check(rises == 1, "R5", "rising edges with N=1", rises, 1);
      stop();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule